// File: doc/BRIEF.md
# Hybrid Segment Access Controller

This block lets software reach a large body of state laid out as wide segments. Each segment is a ring of words, and only one word of the ring, the one at the front, is wired to the block's data port. A shallow radix-4 selection tree picks the segment. The ring moves the rest of the segment past the port one word per clock. This costs far less wiring than giving every word its own path. The price is extra cycles whenever the requested word is not already at the front.

A request names a segment, a word offset and an operation: read, write or rewind. The controller remembers how far each segment has been rotated. It rotates the selected ring by the smallest forward distance that brings the requested word to the front, and then performs the read or the write. Because the rotation is recorded and not undone after each access, no data is lost, and a later access to a nearby word costs only the difference. A rewind brings a segment back to its home alignment. By default there are 64 segments of 512 bits, built from 64-bit words; the parameters allow smaller configurations.

Top module: `hybridAccess`

## Requirements
- R1: After reset, busy and rspValid are low, rspRdata is zero, every stored bit is zero and every segment is at its home alignment (offset 0).
- R2: A request is accepted on a clock edge where reqValid is high and busy is low. A request presented while busy is high is ignored and changes no stored data.
- R3: A read returns on rspRdata the value most recently written to the same segment and word offset, or zero if that word was never written.
- R4: A write stores reqWdata at the given segment and word offset and leaves every other word of every segment unchanged.
- R5: After the accepting edge, busy stays high for ((target − current offset) mod WORDS) + 1 cycles. rspValid is high for exactly one cycle, the first cycle in which busy is low again.
- R6: Each segment keeps its own offset. An access moves only the offset of the segment it selects, and that offset becomes the accessed word offset.
- R7: A rewind (reqOp 2'b10) rotates the segment forward to offset 0 with busy timing as in R5 for target 0. All words stay at their offsets, so later reads return the same data.
- R8: reqOp is encoded as 2'b00 read, 2'b01 write, 2'b10 rewind. The code 2'b11 behaves exactly like a read.
- R9: rspRdata changes only on the response to a read. Writes and rewinds leave it holding its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqOp | input | 2 | Operation: 00 read, 01 write, 10 rewind, 11 read |
| reqSeg | input | $clog2(SEGS) | Segment index |
| reqWord | input | $clog2(SEG_BITS/WORD_W) | Word offset inside the segment |
| reqWdata | input | WORD_W | Write data |
| busy | output | 1 | Request in progress; new requests ignored |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | WORD_W | Data of the last completed read |

## Verification
The assertions assume that WORDS and FANOUT are powers of two and that SEGS is a power of FANOUT, so that offsets wrap naturally and the tree is full. They also assume that the operation and address inputs are sampled only at an accepting edge. The stimulus keeps to the default configuration. During the first busy cycle of every request it drives a conflicting write request, which must be dropped. It mixes reads, writes, rewinds and the spare operation code at random addresses, so rotation distances cover every value from 0 to WORDS−1 and every segment's offset wanders independently.

// File: rtl/accessPkg.sv
package accessPkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_WRITE  = 2'b01,
    OP_REWIND = 2'b10,
    OP_RSVD   = 2'b11
  } accOp_e;

  typedef struct packed {
    logic shiftEn;
    logic writeEn;
  } dpStrobe_t;

endpackage

// File: rtl/segmentChain.sv
module segmentChain #(
  parameter int WORD_W = 64,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              doShift,
  input  logic              doWrite,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] portWord
);

  logic [WORDS-1:0][WORD_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain <= '0;
    end else if (doShift) begin
      chain <= {chain[0], chain[WORDS-1:1]};
    end else if (doWrite) begin
      chain[0] <= wrData;
    end
  end

  assign portWord = chain[0];

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doShift || doWrite) |=> $stable(chain));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    doShift |=> chain[WORDS-1] == $past(chain[0]));

endmodule

// File: rtl/muxTree.sv
module muxTree #(
  parameter int WORD_W = 64,
  parameter int SEGS   = 64,
  parameter int FANOUT = 4
) (
  input  logic [WORD_W-1:0]       leaves [SEGS],
  input  logic [$clog2(SEGS)-1:0] segSel,
  output logic [WORD_W-1:0]       rdWord
);

  localparam int SEG_W  = $clog2(SEGS);
  localparam int SEL_B  = $clog2(FANOUT);
  localparam int LEVELS = SEG_W / SEL_B;

  logic [WORD_W-1:0] lvl [LEVELS+1][SEGS];

  for (genvar i = 0; i < SEGS; i++) begin : g_leaf
    assign lvl[0][i] = leaves[i];
  end

  for (genvar l = 1; l <= LEVELS; l++) begin : g_level
    localparam int NODES = SEGS >> (l * SEL_B);
    logic [SEL_B-1:0] digit;
    assign digit = segSel[(l-1)*SEL_B +: SEL_B];
    for (genvar j = 0; j < SEGS; j++) begin : g_node
      if (j < NODES) begin : g_used
        localparam logic [SEG_W-1:0] BASE = SEG_W'(j * FANOUT);
        assign lvl[l][j] = lvl[l-1][BASE + SEG_W'(digit)];
      end else begin : g_idle
        assign lvl[l][j] = '0;
      end
    end
  end

  assign rdWord = lvl[LEVELS][0];

endmodule

// File: rtl/accessData.sv
module accessData
  import accessPkg::*;
#(
  parameter int WORD_W = 64,
  parameter int WORDS  = 8,
  parameter int SEGS   = 64,
  parameter int FANOUT = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  logic [$clog2(SEGS)-1:0] segSel,
  input  logic [WORD_W-1:0]       wrData,
  output logic [WORD_W-1:0]       rdWord
);

  logic [WORD_W-1:0] leafWord [SEGS];

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    logic hit;
    assign hit = (segSel == ($clog2(SEGS))'(s));
    segmentChain #(.WORD_W(WORD_W), .WORDS(WORDS)) u_chain (
      .clk     (clk),
      .rstN    (rstN),
      .doShift (strobe.shiftEn && hit),
      .doWrite (strobe.writeEn && hit),
      .wrData  (wrData),
      .portWord(leafWord[s])
    );
  end

  muxTree #(.WORD_W(WORD_W), .SEGS(SEGS), .FANOUT(FANOUT)) u_tree (
    .leaves(leafWord),
    .segSel(segSel),
    .rdWord(rdWord)
  );

endmodule

// File: rtl/accessCtrl.sv
module accessCtrl
  import accessPkg::*;
#(
  parameter int WORD_W = 64,
  parameter int WORDS  = 8,
  parameter int SEGS   = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [1:0]               reqOp,
  input  logic [$clog2(SEGS)-1:0]  reqSeg,
  input  logic [$clog2(WORDS)-1:0] reqWord,
  input  logic [WORD_W-1:0]        reqWdata,
  input  logic [WORD_W-1:0]        rdWord,
  output dpStrobe_t                strobe,
  output logic [$clog2(SEGS)-1:0]  curSeg,
  output logic [WORD_W-1:0]        curWdata,
  output logic                     busy,
  output logic                     rspValid,
  output logic [WORD_W-1:0]        rspRdata
);

  localparam int OFF_W = $clog2(WORDS);

  typedef enum logic {ST_IDLE, ST_MOVE} state_e;

  state_e           state;
  accOp_e           curOp;
  logic [OFF_W-1:0] remSteps;
  logic [OFF_W-1:0] offTab [SEGS];
  logic [OFF_W-1:0] offCur;
  logic [OFF_W-1:0] target;
  logic             readOp;

  assign offCur = offTab[curSeg];
  assign target = (accOp_e'(reqOp) == OP_REWIND) ? '0 : reqWord;
  assign readOp = (curOp == OP_READ) || (curOp == OP_RSVD);
  assign busy   = (state == ST_MOVE);

  always_comb begin
    strobe.shiftEn = (state == ST_MOVE) && (remSteps != '0);
    strobe.writeEn = (state == ST_MOVE) && (remSteps == '0) && (curOp == OP_WRITE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curOp    <= OP_READ;
      curSeg   <= '0;
      curWdata <= '0;
      remSteps <= '0;
      rspValid <= 1'b0;
      rspRdata <= '0;
      for (int i = 0; i < SEGS; i++) offTab[i] <= '0;
    end else begin
      rspValid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            curOp    <= accOp_e'(reqOp);
            curSeg   <= reqSeg;
            curWdata <= reqWdata;
            remSteps <= target - offTab[reqSeg];
            state    <= ST_MOVE;
          end
        end
        ST_MOVE: begin
          if (remSteps != '0) begin
            remSteps       <= remSteps - 1'b1;
            offTab[curSeg] <= offTab[curSeg] + 1'b1;
          end else begin
            state    <= ST_IDLE;
            rspValid <= 1'b1;
            if (readOp) rspRdata <= rdWord;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R5
  rsp_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (!busy && $past(busy)));

  // R6
  shift_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> offCur == OFF_W'($past(offCur) + 1'b1));

  // R7
  rewind_home_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && curOp == OP_REWIND) |-> offCur == '0);

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rspValid && readOp) |-> $stable(rspRdata));

endmodule

// File: rtl/hybridAccess.sv
module hybridAccess
  import accessPkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int SEG_BITS = 512,
  parameter int SEGS     = 64,
  parameter int FANOUT   = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                reqValid,
  input  logic [1:0]                          reqOp,
  input  logic [$clog2(SEGS)-1:0]             reqSeg,
  input  logic [$clog2(SEG_BITS/WORD_W)-1:0]  reqWord,
  input  logic [WORD_W-1:0]                   reqWdata,
  output logic                                busy,
  output logic                                rspValid,
  output logic [WORD_W-1:0]                   rspRdata
);

  localparam int WORDS = SEG_BITS / WORD_W;

  dpStrobe_t               strobe;
  logic [$clog2(SEGS)-1:0] curSeg;
  logic [WORD_W-1:0]       curWdata;
  logic [WORD_W-1:0]       rdWord;

  accessCtrl #(.WORD_W(WORD_W), .WORDS(WORDS), .SEGS(SEGS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqOp   (reqOp),
    .reqSeg  (reqSeg),
    .reqWord (reqWord),
    .reqWdata(reqWdata),
    .rdWord  (rdWord),
    .strobe  (strobe),
    .curSeg  (curSeg),
    .curWdata(curWdata),
    .busy    (busy),
    .rspValid(rspValid),
    .rspRdata(rspRdata)
  );

  accessData #(.WORD_W(WORD_W), .WORDS(WORDS), .SEGS(SEGS), .FANOUT(FANOUT)) u_data (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .segSel(curSeg),
    .wrData(curWdata),
    .rdWord(rdWord)
  );

endmodule

// File: tb/hybridAccess_tb.sv
module hybridAccess_tb;

  localparam int WORD_W   = 64;
  localparam int SEG_BITS = 512;
  localparam int SEGS     = 64;
  localparam int WORDS    = SEG_BITS / WORD_W;
  localparam int SEG_W    = $clog2(SEGS);
  localparam int OFF_W    = $clog2(WORDS);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [1:0]        reqOp = '0;
  logic [SEG_W-1:0]  reqSeg = '0;
  logic [OFF_W-1:0]  reqWord = '0;
  logic [WORD_W-1:0] reqWdata = '0;
  logic              busy;
  logic              rspValid;
  logic [WORD_W-1:0] rspRdata;

  int checks = 0;
  int failures = 0;

  logic [WORD_W-1:0] mdl [SEGS][WORDS];
  int                offMdl [SEGS];
  logic [WORD_W-1:0] lastRd = '0;
  int                junkSeg, junkWord;

  always #2.5 clk = ~clk;

  hybridAccess u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqSeg(reqSeg), .reqWord(reqWord), .reqWdata(reqWdata),
    .busy(busy), .rspValid(rspValid), .rspRdata(rspRdata)
  );

  function automatic int stepsTo(int tgt, int cur);
    return (tgt - cur + WORDS) % WORDS;
  endfunction

  task automatic check(bit ok, string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReq(int op, int seg, int word, logic [WORD_W-1:0] data);
    int tgt = (op == 2) ? 0 : word;
    int expCyc = stepsTo(tgt, offMdl[seg]) + 1;
    int cnt = 0;
    bit isRead = (op == 0) || (op == 3);
    reqValid = 1'b1;
    reqOp    = 2'(op);
    reqSeg   = SEG_W'(seg);
    reqWord  = OFF_W'(word);
    reqWdata = data;
    @(posedge clk);
    @(negedge clk);
    // R2: conflicting write during busy must be dropped
    junkSeg  = $urandom_range(SEGS-1);
    junkWord = $urandom_range(WORDS-1);
    reqOp    = 2'b01;
    reqSeg   = SEG_W'(junkSeg);
    reqWord  = OFF_W'(junkWord);
    reqWdata = {$urandom, $urandom};
    while (busy && cnt < 64) begin
      cnt++;
      @(negedge clk);
      if (cnt == 1) reqValid = 1'b0;
    end
    reqValid = 1'b0;
    check(cnt == expCyc, (op == 2) ? "R7 busy cycles" : "R5 busy cycles", WORD_W'(cnt), WORD_W'(expCyc));
    check(rspValid == 1'b1, "R5 rspValid pulse", WORD_W'(rspValid), 1);
    offMdl[seg] = tgt;
    if (op == 1) mdl[seg][word] = data;
    if (isRead) begin
      check(rspRdata == mdl[seg][word], (op == 3) ? "R8 spare code read" : "R3 read data",
            rspRdata, mdl[seg][word]);
      lastRd = mdl[seg][word];
    end else begin
      check(rspRdata == lastRd, "R9 rdata held", rspRdata, lastRd);
    end
    @(negedge clk);
    check(rspValid == 1'b0, "R5 single pulse", WORD_W'(rspValid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < SEGS; s++) begin
      offMdl[s] = 0;
      for (int w = 0; w < WORDS; w++) mdl[s][w] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy low", WORD_W'(busy), 0);
    check(rspValid == 1'b0, "R1 rspValid low", WORD_W'(rspValid), 0);
    check(rspRdata == '0, "R1 rdata zero", rspRdata, 0);
    doReq(0, 0, 0, '0);   // R1 zero content, home alignment
    doReq(0, 17, 5, '0);

    // R4 / R6 directed
    doReq(1, 5, 7, 64'hDEAD_BEEF_0000_0007);
    doReq(0, 5, 7, '0);
    doReq(0, 5, 0, '0);
    doReq(0, 63, 3, '0);
    doReq(0, 5, 0, '0);
    doReq(1, 5, 6, 64'h1234_5678_9ABC_DEF0);
    doReq(0, 5, 7, '0);

    // R7 rewind preserves data
    for (int w = 0; w < WORDS; w++) doReq(1, 9, w, {32'h0909_0000 + w, 32'hA5A5_0000 + w});
    doReq(2, 9, 0, '0);
    for (int w = WORDS - 1; w >= 0; w--) doReq(0, 9, w, '0);
    doReq(2, 9, 0, '0);
    doReq(2, 9, 0, '0);

    // R8 spare code acts as read
    doReq(3, 5, 7, '0);

    // R2 junk targets read back
    for (int k = 0; k < 8; k++) begin
      doReq(0, $urandom_range(SEGS-1), $urandom_range(WORDS-1), '0);
      doReq(0, junkSeg, junkWord, '0);
    end

    // constrained random mix
    for (int n = 0; n < 700; n++) begin
      int r = $urandom_range(99);
      int op = (r < 50) ? 1 : (r < 85) ? 0 : (r < 95) ? 2 : 3;
      int seg = ($urandom_range(3) == 0) ? $urandom_range(SEGS-1) : $urandom_range(7);
      doReq(op, seg, $urandom_range(WORDS-1), {$urandom, $urandom});
    end

    // final sweep of a few segments
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < WORDS; w++) doReq(0, s, w, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule